// File: doc/BRIEF.md
# CAN Bit Timing and Sampler

This block turns a system clock into CAN time quanta and uses them to mark out each bit period on the receive line. A bit period has three parts in a fixed order. A one-quantum synchronisation segment comes first, then a programmable first phase, then a programmable second phase. The block samples the receive line where the first phase ends. At that point it reports the resolved bit value on `bit_o`, together with a one-clock strobe on `bit_vld_o`.

An 8-bit timing register selects the sampling mode and the lengths of the two phases. This register can only be written while the soft-reset input is high. While the bus is idle, a recessive-to-dominant edge on the receive line restarts the bit timer. This aligns the sampling with the start of a frame.

Sampling uses one of two modes. In the first, the line is read once per bit. In the second, the line is read at the sample point and at the ends of the two quanta before it, and the bit is decided by a two-of-three vote.

Top module: `can_bit_timing`

## Requirements
- R1: After reset `cfg_o` reads 0x00 (single sampling, both phases one quantum long), `bit_vld_o` is low and `cfg_bad_o` is low.
- R2: A write on `cfg_we_i` loads `cfg_wdata_i` into the timing register, which is visible on `cfg_o` the next cycle, only when `soft_rst_i` is high. A write made while `soft_rst_i` is low leaves `cfg_o` unchanged.
- R3: One quantum lasts `presc_i`+1 clocks. One bit lasts (1 + L1 + L2) quanta, so successive `bit_vld_o` pulses in a frame are that many clocks apart.
- R4: L1 is field [3:0] plus 1 and L2 is field [6:4] plus 1. After a hard-sync edge, the sample point of the first bit is (L1+1)×(`presc_i`+1) clocks after the clock edge that first sees `rx_i` low. `bit_vld_o` is high in the cycle that follows that sample point.
- R5: With bit 7 of the timing register at 0, `bit_o` equals the value of `rx_i` at the sample-point clock edge.
- R6: With bit 7 at 1, `bit_o` is the majority of `rx_i` taken at three edges: the sample point, one quantum before it and two quanta before it. A single disturbed sample does not change the result, and two disturbed samples do.
- R7: Each `bit_vld_o` pulse lasts exactly one clock, and there is exactly one pulse per bit period.
- R8: A falling edge on `rx_i` while `bus_idle_i` is high restarts the bit timer at the start of the sync segment. While `bus_idle_i` is low, such edges do not change the timing.
- R9: `cfg_bad_o` is high exactly when bit 7 is 1 and field [3:0] is 0, that is, when triple sampling is selected with a first phase shorter than two quanta.
- R10: While `soft_rst_i` is high the bit timer is held cleared and `bit_vld_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Soft reset; enables timing-register writes and holds the timer |
| cfg_we_i | input | 1 | Timing-register write strobe |
| cfg_wdata_i | input | 8 | Timing-register write data |
| cfg_o | output | 8 | Timing-register contents |
| presc_i | input | 6 | Quantum length minus one, in clocks |
| bus_idle_i | input | 1 | High while no frame is in progress; enables hard sync |
| rx_i | input | 1 | Receive line, 1 = recessive |
| bit_o | output | 1 | Resolved bit at the latest sample point |
| bit_vld_o | output | 1 | One-clock strobe marking a new `bit_o` |
| cfg_bad_o | output | 1 | Timing setting not allowed for triple sampling |

## Verification
The assertions assume three things about the inputs:
- `rx_i` is already synchronous to `clk_i`.
- `presc_i` only changes while `soft_rst_i` is high.
- The register contents are changed only through the write port.

The stimulus keeps to these assumptions. It changes `rx_i` only on falling clock edges and sets `presc_i` during the programming phase under soft reset. Glitches are injected as whole-clock pulses placed at chosen quantum boundaries, so each disturbed sample lands on a known clock edge.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int unsigned TSEG1_W = 4;
  localparam int unsigned TSEG2_W = 3;
  localparam int unsigned CFG_W   = 1 + TSEG2_W + TSEG1_W;
  localparam int unsigned QMAX    = 1 + (1 << TSEG1_W) + (1 << TSEG2_W);
  localparam int unsigned QCNT_W  = $clog2(QMAX);

  typedef struct packed {
    logic               triple;
    logic [TSEG2_W-1:0] tseg2;
    logic [TSEG1_W-1:0] tseg1;
  } bt_cfg_t;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/can_tq_prescaler.sv
module can_tq_prescaler #(
  parameter int unsigned PRESC_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;
  logic               wrap;

  // >= keeps the counter bounded if presc_i drops below cnt_q
  assign wrap   = (cnt_q >= presc_i);
  assign tick_o = wrap && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/can_bit_seq.sv
module can_bit_seq
  import can_bt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               tick_i,
  input  logic [TSEG1_W-1:0] tseg1_i,
  input  logic [TSEG2_W-1:0] tseg2_i,
  output logic               samp_o
);
  logic [QCNT_W-1:0] q_q;
  logic [QCNT_W-1:0] q_last;
  logic [QCNT_W-1:0] q_samp;

  // quantum 0 = sync, 1..L1 = phase 1, L1+1..L1+L2 = phase 2
  assign q_last = QCNT_W'(tseg1_i) + QCNT_W'(tseg2_i) + QCNT_W'(2);
  assign q_samp = QCNT_W'(tseg1_i) + QCNT_W'(1);
  assign samp_o = tick_i && (q_q == q_samp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (clr_i)   q_q <= '0;
    else if (tick_i)  q_q <= (q_q >= q_last) ? '0 : q_q + 1'b1;
  end
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import can_bt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic samp_i,
  input  logic triple_i,
  input  logic rx_i,
  output logic bit_o,
  output logic vld_o
);
  logic [1:0] hist_q;
  logic       bit_q;
  logic       vld_q;
  logic       resolved;

  assign resolved = triple_i ? vote3({hist_q, rx_i}) : rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= 2'b11;
      bit_q  <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= samp_i;
      if (tick_i) hist_q <= {hist_q[0], rx_i};
      if (samp_i) bit_q  <= resolved;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
#(
  parameter int unsigned PRESC_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_o,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               bus_idle_i,
  input  logic               rx_i,
  output logic               bit_o,
  output logic               bit_vld_o,
  output logic               cfg_bad_o
);
  bt_cfg_t cfg_q;
  logic    rx_q;
  logic    hsync;
  logic    clr;
  logic    tick;
  logic    samp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cfg_q <= '0;
    else if (soft_rst_i && cfg_we_i) cfg_q <= bt_cfg_t'(cfg_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  assign hsync = bus_idle_i && rx_q && !rx_i;
  assign clr   = soft_rst_i || hsync;

  can_tq_prescaler #(.PRESC_W(PRESC_W)) i_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .presc_i (presc_i),
    .tick_o  (tick)
  );

  can_bit_seq i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (tick),
    .tseg1_i (cfg_q.tseg1),
    .tseg2_i (cfg_q.tseg2),
    .samp_o  (samp)
  );

  can_bit_sampler i_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .samp_i   (samp),
    .triple_i (cfg_q.triple),
    .rx_i     (rx_i),
    .bit_o    (bit_o),
    .vld_o    (bit_vld_o)
  );

  assign cfg_o     = cfg_q;
  assign cfg_bad_o = cfg_q.triple && (cfg_q.tseg1 == '0);
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       cfg_we_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] cfg_o,
  input logic       rx_i,
  input logic       bit_o,
  input logic       bit_vld_o,
  input logic       cfg_bad_o
);
  p_vld_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);

  p_cfg_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(soft_rst_i && cfg_we_i) |=> $stable(cfg_o));

  p_cfg_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && cfg_we_i) |=> (cfg_o == $past(cfg_wdata_i)));

  p_bad_needs_triple_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bad_o |-> cfg_o[7]);

  p_quiet_soft_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !bit_vld_o);

  p_single_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_o && !cfg_o[7]) |-> (bit_o == $past(rx_i)));
endmodule

bind can_bit_timing can_bit_timing_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_o       (cfg_o),
  .rx_i        (rx_i),
  .bit_o       (bit_o),
  .bit_vld_o   (bit_vld_o),
  .cfg_bad_o   (cfg_bad_o)
);

// File: tb/test_can_bit_timing.sv
module test_can_bit_timing;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {cfg[7:0], presc[5:0], pattern[15:0] (bit 0 sent first), nbits[3:0]}
  localparam logic [33:0] VEC [0:NVEC-1] = '{
    {8'h00, 6'd0, 16'h0356, 4'd10},
    {8'h23, 6'd2, 16'h02B4, 4'd10},
    {8'hA5, 6'd1, 16'h01E2, 4'd10},
    {8'h7F, 6'd0, 16'h0318, 4'd10},
    {8'h81, 6'd3, 16'h0154, 4'd10}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rd;
  logic [5:0] presc = 6'd0;
  logic       bus_idle = 1'b1;
  logic       rx = 1'b1;
  logic       bit_val;
  logic       bit_vld;
  logic       cfg_bad;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int edge_cyc = 32'h7fffffff;
  int rec_n = 0;
  int rec_bit [0:63];
  int rec_cyc [0:63];
  int vld_total = 0;
  int wide_cnt = 0;
  logic prev_vld = 1'b0;
  bit done = 1'b0;

  can_bit_timing i_can_bit_timing (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .soft_rst_i  (soft_rst),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_o       (cfg_rd),
    .presc_i     (presc),
    .bus_idle_i  (bus_idle),
    .rx_i        (rx),
    .bit_o       (bit_val),
    .bit_vld_o   (bit_vld),
    .cfg_bad_o   (cfg_bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bit_vld) vld_total++;
    if (bit_vld && prev_vld) wide_cnt++;
    prev_vld = bit_vld;
    if (bit_vld && cyc > edge_cyc && rec_n < 64) begin
      rec_bit[rec_n] = int'(bit_val);
      rec_cyc[rec_n] = cyc;
      rec_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic program_cfg(input logic [7:0] c, input logic [5:0] p);
    @(negedge clk);
    soft_rst = 1'b1; cfg_we = 1'b1; cfg_wdata = c; presc = p;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rd == c, "R2 load under soft reset", int'(cfg_rd), int'(c));
    soft_rst = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  // drive one frame; optional glitch on bit gk, clocks [gj, gj+gl) of that bit
  task automatic run_frame(input logic [7:0] c, input logic [5:0] pr,
                           input logic [15:0] pat, input int nbits,
                           input int gk, input int gj, input int gl);
    int l1, l2, p, t, hit, ex;
    int pos [0:2];
    l1 = int'(c[3:0]) + 1;
    l2 = int'(c[6:4]) + 1;
    p  = int'(pr) + 1;
    t  = (1 + l1 + l2) * p;
    program_cfg(c, pr);
    @(posedge clk);
    rec_n = 0;
    edge_cyc = 32'h7fffffff;
    @(negedge clk);
    edge_cyc = cyc;
    for (int k = 0; k < nbits; k++) begin
      for (int j = 0; j < t; j++) begin
        rx = pat[k] ^ ((k == gk) && (j >= gj) && (j < gj + gl));
        @(negedge clk);
        bus_idle = 1'b0;
      end
    end
    rx = 1'b1;
    bus_idle = 1'b1;
    @(negedge clk);
    chk(rec_n >= nbits, "R7 one pulse per bit", rec_n, nbits);
    if (rec_n >= nbits) begin
      chk(rec_cyc[0] - edge_cyc == (l1 + 1) * p + 1, "R4 R8 first sample after hard sync",
          rec_cyc[0] - edge_cyc, (l1 + 1) * p + 1);
      for (int i = 0; i < nbits; i++) begin
        ex = int'(pat[i]);
        if (i == gk) begin
          pos[0] = (l1 - 1) * p; pos[1] = l1 * p; pos[2] = (l1 + 1) * p;
          hit = 0;
          for (int m = 0; m < 3; m++)
            if ((c[7] || m == 2) && pos[m] >= gj && pos[m] < gj + gl) hit++;
          if (c[7] ? (hit >= 2) : (hit >= 1)) ex = 1 - ex;
        end
        chk(rec_bit[i] == ex, c[7] ? "R6 triple vote bit" : "R5 single sample bit",
            rec_bit[i], ex);
        if (i > 0)
          chk(rec_cyc[i] - rec_cyc[i-1] == t, "R3 bit period",
              rec_cyc[i] - rec_cyc[i-1], t);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    chk(cfg_rd == 8'h00, "R1 reset cfg", int'(cfg_rd), 0);
    chk(bit_vld == 1'b0, "R1 reset vld", int'(bit_vld), 0);
    chk(cfg_bad == 1'b0, "R1 reset bad", int'(cfg_bad), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: write with soft reset low is ignored
    cfg_we = 1'b1; cfg_wdata = 8'h55;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk(cfg_rd == 8'h00, "R2 write ignored", int'(cfg_rd), 0);

    for (int n = 0; n < NVEC; n++)
      run_frame(VEC[n][33:26], VEC[n][25:20], VEC[n][19:4], int'(VEC[n][3:0]), -1, 0, 0);

    // R6: one disturbed early sample is outvoted
    run_frame(8'h85, 6'd1, 16'h0356, 8, 3, 5 * 2, 1);
    // R6: two disturbed samples flip the bit
    run_frame(8'h85, 6'd1, 16'h0356, 8, 3, 6 * 2, 3);
    // R5: glitch at the sample point flips the bit
    run_frame(8'h05, 6'd1, 16'h0356, 8, 2, 7 * 2, 1);
    // R5: glitch before the sample point has no effect
    run_frame(8'h05, 6'd1, 16'h0356, 8, 2, 6 * 2, 1);
    // R8: falling edge inside a frame does not resync
    run_frame(8'h13, 6'd1, 16'h0356, 8, 2, 1, 1);

    // R9
    program_cfg(8'h80, 6'd0);
    chk(cfg_bad == 1'b1, "R9 triple with short phase", int'(cfg_bad), 1);
    program_cfg(8'h81, 6'd0);
    chk(cfg_bad == 1'b0, "R9 triple with 2 quanta", int'(cfg_bad), 0);
    program_cfg(8'h00, 6'd0);
    chk(cfg_bad == 1'b0, "R9 single with short phase", int'(cfg_bad), 0);

    // R10: no samples while soft reset holds the timer
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    v0 = vld_total;
    for (int i = 0; i < 60; i++) begin
      rx = i[2];
      @(negedge clk);
    end
    chk(vld_total == v0, "R10 quiet in soft reset", vld_total - v0, 0);
    soft_rst = 1'b0;
    rx = 1'b1;
    repeat (5) @(negedge clk);

    chk(wide_cnt == 0, "R7 pulse width", wide_cnt, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule